// File: doc/BRIEF.md
# Beat-Sampling Jitter Estimator

This block measures clock jitter from a single bit stream. The stream comes from sampling one free-running clock with a second clock whose frequency is very close. The two clocks drift against each other by one full period per beat. As a result the sampled bit shows long steady runs of ones and of zeros. Between the runs sit noisy stretches where the two values interleave. With no jitter, each change of value would take a single sample. The width of a noisy stretch therefore tells how much the edges wander compared with the whole slip.

Each sample clock edge takes one sample. The block sorts the stream into confirmed stable runs and transition zones, and measures the length of every zone in samples. It also counts the length of the full beat cycle, from one zero-to-one zone to the next. When a beat cycle closes, a multi-cycle restoring divider turns the two counts into a jitter figure in picoseconds: the sample period times the zone length, divided by the cycle length. The result appears with a one-cycle valid pulse. Removing a baseline jitter measured without the device under test is left to software.

Top module: `beat_jitter_est`

## Requirements
- R1: A value becomes a stable run once it has held for T consecutive samples, where T is stable_thr_i and any setting below 2 is taken as 2; nothing is measured before the first stable run after reset.
- R2: A transition zone begins at the first sample that differs from the current stable value and ends just before the run that confirms the next stable value; that run is excluded from the zone length, so an instantaneous switch has zone length 0.
- R3: A zone that settles back to the stable value it left is discarded and changes neither the reported zone length nor the cycle length.
- R4: tc_o is the number of samples from the first sample of one rising zone (stable 0 to stable 1) to the first sample of the next rising zone; a falling zone does not restart this count.
- R5: tt_o is floor((R + F) / 2), where R is the length of the rising zone that opened the closed cycle and F is the length of the falling zone inside it.
- R6: jit_ps_o is floor(P * tt_o / tc_o), where P is period_ps_i at the sample that confirms the closing rising zone; tt_o, tc_o and jit_ps_o change only in the cycle where valid_o is high, and valid_o is high for one cycle per accepted result.
- R7: After reset, tt_o, tc_o, jit_ps_o, valid_o and ovf_o are 0, and no result appears before a second rising zone has been confirmed.
- R8: Let c be the confirming sample of the last accepted cycle. A cycle whose confirming sample lies PW+CW or fewer samples after c closes while the divider is busy, and its result is dropped; the starting point for the next cycle-length count still moves to this cycle's zone.
- R9: The zone and cycle counters saturate at 2^CW-1 instead of wrapping. A saturation sets ovf_o, which stays high until reset and never rises while the counts stay below that limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; one sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_i | input | 1 | Sampled bit, already synchronized to clk |
| period_ps_i | input | PW | Period of the sampled clock in picoseconds |
| stable_thr_i | input | CW | Samples of equal value needed to confirm a stable run |
| tt_o | output | CW | Averaged transition zone length in samples |
| tc_o | output | CW | Beat cycle length in samples |
| jit_ps_o | output | PW+CW | Jitter estimate in picoseconds |
| valid_o | output | 1 | One-cycle pulse when a new result is presented |
| ovf_o | output | 1 | Sticky counter saturation flag |

## Verification
The hardest situations to reach from the ports are a beat cycle that closes while the divider is still working and a cycle counter that runs into its limit. A real slip cycle is far longer than the division, and reaching the counter limit at the default width takes millions of samples. The bench narrows the counter width and inserts a minimal beat, with instant switches and stable runs only as long as the threshold, right after an accepted cycle so that it lands inside the busy window. It then holds one level for a few thousand samples to drive the cycle count into saturation. Zones made of random run lengths that stay below the threshold, together with zones that fall back to their starting value, cover the classification around them.

// File: rtl/bje_pkg.sv
package bje_pkg;

  typedef enum logic [1:0] {
    ZS_UNK  = 2'd0,
    ZS_STB  = 2'd1,
    ZS_ZONE = 2'd2
  } zstate_e;

  typedef enum logic [1:0] {
    ZE_NONE   = 2'd0,
    ZE_RISE   = 2'd1,
    ZE_FALL   = 2'd2,
    ZE_GLITCH = 2'd3
  } zend_e;

endpackage

// File: rtl/bje_classify.sv
module bje_classify
  import bje_pkg::*;
#(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_i,
  input  logic [CW-1:0] thr_i,
  output logic          zstart_o,
  output logic          zfrom_o,
  output zend_e         zend_o,
  output logic [CW-1:0] zlen_o,
  output logic [CW-1:0] zspan_o,
  output logic          sat_o
);

  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] TMIN = CW'(2);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          last_q, last_n;
  logic [CW-1:0] run_q, run_n;
  zstate_e       st_q, st_n;
  logic          sv_q, sv_n;
  logic [CW-1:0] zc_q, zc_n;

  logic [CW-1:0] thr_eff;
  logic          same;
  logic          confirm;
  logic [CW-1:0] zc_inc;

  always_comb begin
    thr_eff = (thr_i < TMIN) ? TMIN : thr_i;
    same    = (smp_i == last_q);
    last_n  = smp_i;
    if (!same)                run_n = ONE;
    else if (run_q >= thr_eff) run_n = run_q;
    else                      run_n = run_q + ONE;
    confirm = same && ((run_q + ONE) == thr_eff);
    zc_inc  = (zc_q == CMAX) ? CMAX : (zc_q + ONE);

    st_n     = st_q;
    sv_n     = sv_q;
    zc_n     = zc_q;
    zstart_o = 1'b0;
    zend_o   = ZE_NONE;
    sat_o    = 1'b0;

    case (st_q)
      ZS_UNK: begin
        if (confirm) begin
          st_n = ZS_STB;
          sv_n = smp_i;
        end
      end
      ZS_STB: begin
        if (smp_i != sv_q) begin
          st_n     = ZS_ZONE;
          zc_n     = ONE;
          zstart_o = 1'b1;
        end
      end
      ZS_ZONE: begin
        zc_n  = zc_inc;
        sat_o = (zc_q == CMAX);
        if (confirm) begin
          st_n = ZS_STB;
          sv_n = smp_i;
          if (smp_i == sv_q) zend_o = ZE_GLITCH;
          else if (smp_i)    zend_o = ZE_RISE;
          else               zend_o = ZE_FALL;
        end
      end
      default: st_n = ZS_UNK;
    endcase
  end

  assign zfrom_o = sv_q;
  assign zspan_o = zc_inc;
  assign zlen_o  = zc_inc - thr_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      run_q  <= '0;
      st_q   <= ZS_UNK;
      sv_q   <= 1'b0;
      zc_q   <= '0;
    end else begin
      last_q <= last_n;
      run_q  <= run_n;
      st_q   <= st_n;
      sv_q   <= sv_n;
      zc_q   <= zc_n;
    end
  end

endmodule

// File: rtl/bje_cycle.sv
module bje_cycle
  import bje_pkg::*;
#(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          zstart_i,
  input  logic          zfrom_i,
  input  zend_e         zend_i,
  input  logic [CW-1:0] zlen_i,
  input  logic [CW-1:0] zspan_i,
  output logic          req_o,
  output logic [CW-1:0] tt_o,
  output logic [CW-1:0] tc_o,
  output logic          sat_o
);

  localparam logic [CW-1:0] CMAX = '1;

  logic          ref_q, ref_n;
  logic [CW-1:0] cyc_q, cyc_n;
  logic [CW-1:0] cand_q, cand_n;
  logic [CW-1:0] rise_q, rise_n;
  logic [CW-1:0] fall_q, fall_n;
  logic [CW:0]   zsum;

  always_comb begin
    sat_o  = ref_q && (cyc_q == CMAX);
    cyc_n  = ref_q ? (sat_o ? CMAX : (cyc_q + CW'(1))) : cyc_q;
    cand_n = (zstart_i && !zfrom_i) ? cyc_q : cand_q;
    ref_n  = ref_q;
    rise_n = rise_q;
    fall_n = fall_q;
    req_o  = 1'b0;

    case (zend_i)
      ZE_RISE: begin
        req_o  = ref_q;
        ref_n  = 1'b1;
        rise_n = zlen_i;
        cyc_n  = zspan_i;
      end
      ZE_FALL: fall_n = zlen_i;
      default: ;
    endcase

    zsum = {1'b0, rise_q} + {1'b0, fall_q};
    tt_o = CW'(zsum >> 1);
    tc_o = cand_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= 1'b0;
      cyc_q  <= '0;
      cand_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      ref_q  <= ref_n;
      cyc_q  <= cyc_n;
      cand_q <= cand_n;
      rise_q <= rise_n;
      fall_q <= fall_n;
    end
  end

endmodule

// File: rtl/bje_div.sv
module bje_div #(
  parameter int NW = 40,
  parameter int DV = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [NW-1:0] num_i,
  input  logic [DV-1:0] den_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [NW-1:0] quo_o
);

  localparam int CNTW = $clog2(NW + 1);

  logic            busy_q, busy_n;
  logic            done_q, done_n;
  logic [CNTW-1:0] cnt_q, cnt_n;
  logic [DV-1:0]   rem_q, rem_n;
  logic [DV-1:0]   den_q, den_n;
  logic [NW-1:0]   quo_q, quo_n;
  logic [DV:0]     shin;
  logic            fits;

  always_comb begin
    shin   = {rem_q, quo_q[NW-1]};
    fits   = (shin >= {1'b0, den_q});
    busy_n = busy_q;
    done_n = 1'b0;
    cnt_n  = cnt_q;
    rem_n  = rem_q;
    den_n  = den_q;
    quo_n  = quo_q;
    if (start_i) begin
      busy_n = 1'b1;
      cnt_n  = CNTW'(NW);
      rem_n  = '0;
      den_n  = den_i;
      quo_n  = num_i;
    end else if (busy_q) begin
      rem_n = fits ? DV'(shin - {1'b0, den_q}) : DV'(shin);
      quo_n = {quo_q[NW-2:0], fits};
      cnt_n = cnt_q - CNTW'(1);
      if (cnt_q == CNTW'(1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      cnt_q  <= cnt_n;
      rem_q  <= rem_n;
      den_q  <= den_n;
      quo_q  <= quo_n;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quo_o  = quo_q;

endmodule

// File: rtl/beat_jitter_est.sv
module beat_jitter_est
  import bje_pkg::*;
#(
  parameter int CW = 24,
  parameter int PW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_i,
  input  logic [PW-1:0]    period_ps_i,
  input  logic [CW-1:0]    stable_thr_i,
  output logic [CW-1:0]    tt_o,
  output logic [CW-1:0]    tc_o,
  output logic [PW+CW-1:0] jit_ps_o,
  output logic             valid_o,
  output logic             ovf_o
);

  localparam int DW = PW + CW;

  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  logic          zstart, zfrom, zsat;
  zend_e         zend;
  logic [CW-1:0] zlen, zspan;
  logic          req, csat;
  logic [CW-1:0] cyc_tt, cyc_tc;
  logic          div_busy, div_done, accept;
  logic [DW-1:0] div_quo, div_num;

  bje_classify #(.CW(CW)) u_cls (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .smp_i    (smp_i),
    .thr_i    (stable_thr_i),
    .zstart_o (zstart),
    .zfrom_o  (zfrom),
    .zend_o   (zend),
    .zlen_o   (zlen),
    .zspan_o  (zspan),
    .sat_o    (zsat)
  );

  bje_cycle #(.CW(CW)) u_cyc (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .zstart_i (zstart),
    .zfrom_i  (zfrom),
    .zend_i   (zend),
    .zlen_i   (zlen),
    .zspan_i  (zspan),
    .req_o    (req),
    .tt_o     (cyc_tt),
    .tc_o     (cyc_tc),
    .sat_o    (csat)
  );

  assign accept  = req && !div_busy;
  assign div_num = DW'(period_ps_i) * DW'(cyc_tt);

  bje_div #(.NW(DW), .DV(CW)) u_div (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (accept),
    .num_i   (div_num),
    .den_i   (cyc_tc),
    .busy_o  (div_busy),
    .done_o  (div_done),
    .quo_o   (div_quo)
  );

  logic [CW-1:0] pend_tt_q, pend_tt_n, pend_tc_q, pend_tc_n;
  logic [CW-1:0] tt_q, tt_n, tc_q, tc_n;
  logic [DW-1:0] jit_q, jit_n;
  logic          vld_q, vld_n;
  logic          ovf_q, ovf_n;

  always_comb begin
    pend_tt_n = accept ? cyc_tt : pend_tt_q;
    pend_tc_n = accept ? cyc_tc : pend_tc_q;
    tt_n      = div_done ? pend_tt_q : tt_q;
    tc_n      = div_done ? pend_tc_q : tc_q;
    jit_n     = div_done ? div_quo   : jit_q;
    vld_n     = div_done;
    ovf_n     = ovf_q | zsat | csat;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pend_tt_q <= '0;
      pend_tc_q <= '0;
      tt_q      <= '0;
      tc_q      <= '0;
      jit_q     <= '0;
      vld_q     <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      pend_tt_q <= pend_tt_n;
      pend_tc_q <= pend_tc_n;
      tt_q      <= tt_n;
      tc_q      <= tc_n;
      jit_q     <= jit_n;
      vld_q     <= vld_n;
      ovf_q     <= ovf_n;
    end
  end

  assign tt_o     = tt_q;
  assign tc_o     = tc_q;
  assign jit_ps_o = jit_q;
  assign valid_o  = vld_q;
  assign ovf_o    = ovf_q;

endmodule

// File: rtl/bje_chk.sv
module bje_chk #(
  parameter int CW = 24,
  parameter int PW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CW-1:0]    tt_o,
  input logic [CW-1:0]    tc_o,
  input logic [PW+CW-1:0] jit_ps_o,
  input logic             valid_o,
  input logic             ovf_o
);

  // R6: one cycle per result
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R6: results only move together with the valid pulse
  a_r6_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(tt_o) && $stable(tc_o) && $stable(jit_ps_o)));

  // R7: a presented result always has a real cycle length
  a_r7_tc_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (tc_o != '0));

  // R5: the averaged zone is shorter than the cycle it sits in
  a_r5_tt_below_tc: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ovf_o) |-> (tt_o < tc_o));

  // R9: saturation flag is sticky
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);

endmodule

bind beat_jitter_est bje_chk #(.CW(CW), .PW(PW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tt_o     (tt_o),
  .tc_o     (tc_o),
  .jit_ps_o (jit_ps_o),
  .valid_o  (valid_o),
  .ovf_o    (ovf_o)
);

// File: tb/tb_beat_jitter_est.sv
`timescale 1ns/1ps
module tb_beat_jitter_est;

  localparam int CW = 12;
  localparam int PW = 16;
  localparam int DW = PW + CW;

  logic          clk;
  logic          rst_n;
  logic          smp;
  logic [PW-1:0] per;
  logic [CW-1:0] thr;
  logic [CW-1:0] tt, tc;
  logic [DW-1:0] jit;
  logic          vld, ovf;

  beat_jitter_est #(.CW(CW), .PW(PW)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_i        (smp),
    .period_ps_i  (per),
    .stable_thr_i (thr),
    .tt_o         (tt),
    .tc_o         (tc),
    .jit_ps_o     (jit),
    .valid_o      (vld),
    .ovf_o        (ovf)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int idx   = 0;
  int thr_e;
  int have_ref, last_rise, prev_rise_l, fall_l, acc_any, last_acc;
  int n_exp, n_got;
  longint e_tt [0:511];
  longint e_tc [0:511];
  longint e_j  [0:511];
  int unsigned rs;

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // result monitor: R4 R5 R6 against the model queue
  always @(negedge clk) begin
    if (rst_n && vld) begin
      if (n_got >= n_exp) begin
        chk("R8 unexpected result", n_got + 1, n_exp);
      end else begin
        chk("R2 R5 tt", longint'(tt), e_tt[n_got]);
        chk("R3 R4 tc", longint'(tc), e_tc[n_got]);
        chk("R6 jitter", longint'(jit), e_j[n_got]);
      end
      n_got++;
    end
  end

  task automatic model_clear();
    have_ref = 0; acc_any = 0; last_acc = 0;
    last_rise = 0; prev_rise_l = 0; fall_l = 0;
    n_exp = 0; n_got = 0;
  endtask

  task automatic put(input bit b);
    @(negedge clk);
    smp = b;
    idx++;
  endtask

  task automatic stable(input bit v, input int n);
    for (int i = 0; i < n; i++) put(v);
  endtask

  // k runs, alternating, starting with the opposite of v, each shorter than thr_e
  task automatic zone(input bit v, input int k, output int len);
    bit b;
    b = !v;
    len = 0;
    for (int i = 0; i < k; i++) begin
      int r;
      r = 1 + int'($urandom_range(thr_e - 2, 0));
      for (int j = 0; j < r; j++) put(b);
      len += r;
      b = !b;
    end
  endtask

  task automatic do_rise(input int k);
    int s, l, c;
    longint t_e, c_e;
    s = idx;
    zone(1'b0, k, l);
    c = s + l + thr_e - 1;
    if (have_ref != 0) begin
      c_e = longint'(s - last_rise);
      t_e = longint'((prev_rise_l + fall_l) / 2);
      if (acc_any == 0 || (c - last_acc) > DW) begin
        e_tt[n_exp] = t_e;
        e_tc[n_exp] = c_e;
        e_j[n_exp]  = (longint'(per) * t_e) / c_e;
        n_exp++;
        acc_any  = 1;
        last_acc = c;
      end
    end
    have_ref    = 1;
    last_rise   = s;
    prev_rise_l = l;
  endtask

  task automatic do_fall(input int k);
    int l;
    zone(1'b1, k, l);
    fall_l = l;
  endtask

  task automatic beat(input int kr, input int s1, input int g1,
                      input int kf, input int s0, input int g0);
    int dummy;
    do_rise(kr);
    stable(1'b1, s1);
    if (g1 > 0) begin
      zone(1'b1, g1, dummy);   // R3: falls back to 1
      stable(1'b1, thr_e + 2);
    end
    do_fall(kf);
    stable(1'b0, s0);
    if (g0 > 0) begin
      zone(1'b0, g0, dummy);   // R3: falls back to 0
      stable(1'b0, thr_e + 2);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    smp   = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_clear();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_got, n_exp);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rs    = $urandom(32'd2024);
    rst_n = 1'b0;
    smp   = 1'b0;
    per   = 16'd20000;
    thr   = CW'(4);
    thr_e = 4;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7: reset state
    chk("R7 tt after reset", longint'(tt), 0);
    chk("R7 tc after reset", longint'(tc), 0);
    chk("R7 jitter after reset", longint'(jit), 0);
    chk("R7 valid after reset", longint'(vld), 0);
    chk("R7 ovf after reset", longint'(ovf), 0);

    // R1: first stable run, then one full cycle with no result yet
    stable(1'b0, 10);
    beat(2, 12, 0, 2, 12, 0);
    stable(1'b0, DW + 6);
    chk("R7 no result after first cycle", n_got, 0);
    chk("R7 tc held at zero", longint'(tc), 0);

    // R2: instantaneous rising switch, R3: glitch zones on both levels
    beat(0, 10, 0, 4, 15, 0);
    beat(4, 20, 1, 0, 20, 3);
    beat(2, 25, 3, 2, 25, 1);
    stable(1'b0, DW + 6);
    chk("R2 R3 directed result count", n_got, n_exp);

    // R8: minimal beat that closes inside the busy window, then normal beats
    beat(0, 4, 0, 0, 4, 0);
    beat(2, 30, 0, 2, 40, 0);
    beat(2, 30, 0, 2, 40, 0);
    stable(1'b0, DW + 6);
    chk("R8 result count with drop", n_got, n_exp);
    chk("R8 accepted results", n_exp, 5);

    // random phase with several thresholds and periods
    for (int ph = 0; ph < 3; ph++) begin
      do_reset();
      thr   = CW'(2 + $urandom_range(4, 0));
      thr_e = int'(thr);
      per   = PW'(1000 + $urandom_range(60000, 0));
      stable(1'b0, thr_e + 5);
      for (int b = 0; b < 12; b++) begin
        beat(2 * int'($urandom_range(3, 0)),
             thr_e + int'($urandom_range(60, 0)),
             ($urandom_range(3, 0) == 0) ? 1 + 2 * int'($urandom_range(1, 0)) : 0,
             2 * int'($urandom_range(3, 0)),
             thr_e + int'($urandom_range(60, 0)),
             ($urandom_range(3, 0) == 0) ? 1 + 2 * int'($urandom_range(1, 0)) : 0);
      end
      stable(1'b0, DW + 6);
      chk("R6 R8 random result count", n_got, n_exp);
      chk("R9 no false overflow", longint'(ovf), 0);
    end

    // R1: threshold below 2 acts as 2
    do_reset();
    thr   = CW'(1);
    thr_e = 2;
    per   = 16'd12345;
    stable(1'b0, 6);
    for (int b = 0; b < 6; b++) begin
      beat(2 * int'($urandom_range(4, 0)), 2 + int'($urandom_range(40, 0)), 0,
           2 * int'($urandom_range(4, 0)), 2 + int'($urandom_range(40, 0)), 1);
    end
    stable(1'b0, DW + 6);
    chk("R1 clamped threshold result count", n_got, n_exp);
    chk("R1 clamped threshold produced results", longint'(n_exp > 0), 1);

    // R9: long level drives the cycle count to its limit
    chk("R9 ovf low before saturation", longint'(ovf), 0);
    stable(1'b0, 4300);
    chk("R9 ovf set by saturation", longint'(ovf), 1);
    stable(1'b0, 20);
    chk("R9 ovf stays set", longint'(ovf), 1);
    do_reset();
    chk("R9 ovf cleared by reset", longint'(ovf), 0);
    chk("R7 tc cleared by reset", longint'(tc), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule